// File: doc/BRIEF.md
# Oversampling Serial Receiver with Per-Character Status Queue

This block receives asynchronous serial characters on a single line. It samples the line at sixteen times the bit rate, using a tick from an external rate generator. It rebuilds 7-bit or 8-bit characters, sent least significant bit first, with an optional even or odd parity bit and one stop bit. Each finished character goes into a first-in first-out queue. Its framing, parity, break and overrun indications are stored with it, so every status bit always describes the character currently shown at the read port.

A register-style read port shows the oldest stored character and its flags. A one-cycle pop request discards that character and moves the next one up. Three level indications can each be enabled as an interrupt source: the queue holds data, the queue is getting full, and the queue is nearly full. A loopback select makes the receiver take its input from the local transmit stream instead of the line pin. A request-to-send output is either driven by software or negated automatically when the queue is nearly full.

Top module: `uart_rxs_top`

## Requirements
- R1: While `rx_en` is 0 no character is received and the queue is emptied, so `data_rdy` reads 0 from the next cycle on. After reset, `data_rdy`, `fifo_half`, `fifo_full` and `irq` are 0.
- R2: With `char8`=1, eight data bits are received and delivered unchanged. With `char8`=0, seven data bits are received and bit 7 of `rd_data` is 0.
- R3: `data_rdy` is 1 exactly when the queue holds at least one character. A one-cycle `rd_pop` while `data_rdy` is 1 removes the character at the head.
- R4: With DEPTH=12, `fifo_half` is 1 when 4 or fewer slots are free (8 or more stored). `fifo_full` is 1 when 1 or fewer slots are free (11 or more stored).
- R5: `err_break` marks a character whose data bits, parity bit (when parity is enabled) and stop bit were all 0. Such a character also has `err_frame`=1. It has `err_parity`=1 when odd parity is selected.
- R6: With `par_en`=1, the parity bit follows the data bits. With `par_odd`=0, the data bits plus the parity bit must hold an even number of ones; with `par_odd`=1, an odd number. `err_parity` is 1 when this does not hold, and it is always 0 for a character received with `par_en`=0.
- R7: `err_frame` is 1 for a character whose stop bit was sampled as 0.
- R8: A character that completes while the queue is full is lost. The next character that is stored carries `err_overrun`=1. Characters stored while nothing was lost carry `err_overrun`=0.
- R9: With `loop_en`=1 the receiver takes its input from `loop_txd` and ignores `rxd`.
- R10: With `rts_auto`=0, `rts_n` is the inverse of `rts_sw`. With `rts_auto`=1, `rts_n` is 1 while `fifo_full` is 1 and 0 otherwise.
- R11: A falling edge starts a character only if the line is still low at the eighth tick after the edge (mid start bit). A shorter low pulse returns the receiver to idle and stores nothing.
- R12: `irq` is the OR of the enabled level indications: `irq_en[0]` enables `data_rdy`, `irq_en[1]` enables `fifo_half`, and `irq_en[2]` enables `fifo_full`.
- R13: Characters are read out in arrival order, and data bits are taken least significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Pulse at sixteen times the bit rate |
| rxd | input | 1 | Serial line input, idles high |
| loop_txd | input | 1 | Local transmit stream used in loopback |
| loop_en | input | 1 | Select loopback input |
| rx_en | input | 1 | Receiver enable; 0 flushes the queue |
| char8 | input | 1 | 1 selects 8 data bits, 0 selects 7 |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| rts_auto | input | 1 | RTS follows queue level |
| rts_sw | input | 1 | Software RTS bit (1 drives pin low) |
| irq_en | input | 3 | Interrupt enables: full, half, ready |
| rd_pop | input | 1 | Remove head character |
| rd_data | output | 8 | Head character |
| data_rdy | output | 1 | Queue not empty |
| fifo_half | output | 1 | Four or fewer free slots |
| fifo_full | output | 1 | One or fewer free slots |
| err_frame | output | 1 | Head character stop bit was 0 |
| err_parity | output | 1 | Head character parity mismatch |
| err_break | output | 1 | Head character was a break |
| err_overrun | output | 1 | Characters were lost before the head |
| rts_n | output | 1 | Request-to-send pin, active low |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench checks each possible combination of a break with the parity setting. An all-zero character under odd parity must also raise the parity flag, while under even parity it must not; a design that treated break as separate from parity would miss one of the two cases. The queue thresholds are checked one character on each side of each threshold, 7 against 8 stored and 10 against 11, because an off-by-one compare moves `fifo_half`, `fifo_full` and the automatic `rts_n` by a single character. The bench overfills the queue and then confirms that only the first character stored after the loss carries the overrun flag, which catches a flag that is never set, one that sticks, and one attached to the wrong entry. It also sends a short low glitch, a frame on `rxd` while loopback is selected, and a frame while the receiver is disabled; a design that skipped mid-bit validation or leaked the wrong input would store a character in those cases.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

  // One stored character with the status that travels alongside it.
  typedef struct packed {
    logic [7:0] data;
    logic       fe;
    logic       pe;
    logic       brk;
    logic       ovr;
  } rxs_ent_t;

  localparam int ENT_W = $bits(rxs_ent_t);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rxs_state_t;

endpackage

// File: rtl/uart_rxs_frame.sv
module uart_rxs_frame
  import uart_rxs_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     line_in,
  input  logic     enable,
  input  logic     char8,
  input  logic     par_en,
  input  logic     par_odd,
  output logic     frm_vld,
  output rxs_ent_t frm_ent
);

  localparam int TW  = $clog2(OVS);
  localparam logic [TW-1:0] T_MID  = TW'(OVS / 2 - 1);
  localparam logic [TW-1:0] T_LAST = TW'(OVS - 1);

  // Input synchroniser
  logic [SYNC-1:0] sync_q;
  logic            rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], line_in};
  end
  assign rx_s = sync_q[SYNC-1];

  rxs_state_t    st_q, st_d;
  logic [TW-1:0] tc_q, tc_d;
  logic [2:0]    bc_q, bc_d;
  logic [7:0]    sh_q, sh_d;
  logic          pb_q, pb_d;
  logic          vld_d;
  logic          stop_bit;
  logic [2:0]    last_bit;
  logic [7:0]    data_w;
  logic          perr_w;
  logic          brk_w;

  assign last_bit = char8 ? 3'd7 : 3'd6;
  assign stop_bit = rx_s;
  assign data_w   = char8 ? sh_q : {1'b0, sh_q[7:1]};
  assign perr_w   = par_en & ((^data_w ^ pb_q) != par_odd);
  assign brk_w    = (data_w == 8'h00) & ~(par_en & pb_q) & ~stop_bit;

  always_comb begin
    st_d  = st_q;
    tc_d  = tc_q;
    bc_d  = bc_q;
    sh_d  = sh_q;
    pb_d  = pb_q;
    vld_d = 1'b0;
    if (!enable) begin
      st_d = ST_IDLE;
      tc_d = '0;
      bc_d = '0;
    end else if (tick) begin
      unique case (st_q)
        ST_IDLE: begin
          if (!rx_s) begin
            st_d = ST_START;
            tc_d = '0;
          end
        end
        ST_START: begin
          if (tc_q == T_MID) begin
            tc_d = '0;
            bc_d = '0;
            st_d = rx_s ? ST_IDLE : ST_DATA;
          end else begin
            tc_d = tc_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (tc_q == T_LAST) begin
            tc_d = '0;
            sh_d = {rx_s, sh_q[7:1]};
            bc_d = bc_q + 1'b1;
            if (bc_q == last_bit) st_d = par_en ? ST_PAR : ST_STOP;
          end else begin
            tc_d = tc_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (tc_q == T_LAST) begin
            tc_d = '0;
            pb_d = rx_s;
            st_d = ST_STOP;
          end else begin
            tc_d = tc_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (tc_q == T_LAST) begin
            tc_d  = '0;
            vld_d = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            tc_d = tc_q + 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // Registered result, captured together with the stop bit
  rxs_ent_t ent_q, ent_d;
  logic     vld_q;

  always_comb begin
    ent_d = ent_q;
    if (vld_d) begin
      ent_d.data = data_w;
      ent_d.fe   = ~stop_bit;
      ent_d.pe   = perr_w;
      ent_d.brk  = brk_w;
      ent_d.ovr  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tc_q  <= '0;
      bc_q  <= '0;
      sh_q  <= '0;
      pb_q  <= 1'b0;
      vld_q <= 1'b0;
      ent_q <= '0;
    end else begin
      st_q  <= st_d;
      tc_q  <= tc_d;
      bc_q  <= bc_d;
      sh_q  <= sh_d;
      pb_q  <= pb_d;
      vld_q <= vld_d;
      ent_q <= ent_d;
    end
  end

  assign frm_vld = vld_q;
  assign frm_ent = ent_q;

endmodule

// File: rtl/uart_rxs_fifo.sv
module uart_rxs_fifo #(
  parameter int DEPTH = 12,
  parameter int W     = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] fill
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] C_MAX  = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign do_push = push & (cnt_q != C_MAX) & ~flush;
  assign do_pop  = pop & (cnt_q != '0) & ~flush;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == A_LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == A_LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage has no reset; the count says which slots are meaningful
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wp_q == AW'(g))) mem_q[g] <= din;
    end
  end

  assign dout = mem_q[rp_q];
  assign fill = cnt_q;

endmodule

// File: rtl/uart_rxs_top.sv
module uart_rxs_top
  import uart_rxs_pkg::*;
#(
  parameter int DEPTH     = 12,
  parameter int OVS       = 16,
  parameter int HALF_FREE = 4,
  parameter int FULL_FREE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic       loop_txd,
  input  logic       loop_en,
  input  logic       rx_en,
  input  logic       char8,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rts_auto,
  input  logic       rts_sw,
  input  logic [2:0] irq_en,
  input  logic       rd_pop,
  output logic [7:0] rd_data,
  output logic       data_rdy,
  output logic       fifo_half,
  output logic       fifo_full,
  output logic       err_frame,
  output logic       err_parity,
  output logic       err_break,
  output logic       err_overrun,
  output logic       rts_n,
  output logic       irq
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] C_MAX  = CW'(DEPTH);
  localparam logic [CW-1:0] C_HALF = CW'(DEPTH - HALF_FREE);
  localparam logic [CW-1:0] C_FULL = CW'(DEPTH - FULL_FREE);

  logic     line_sel;
  logic     frm_vld;
  rxs_ent_t frm_ent;
  rxs_ent_t push_ent;
  rxs_ent_t head_ent;
  logic     push;
  logic     lost_q, lost_d;
  logic [CW-1:0] fill;

  assign line_sel = loop_en ? loop_txd : rxd;

  uart_rxs_frame #(.OVS(OVS), .SYNC(2)) i_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .line_in (line_sel),
    .enable  (rx_en),
    .char8   (char8),
    .par_en  (par_en),
    .par_odd (par_odd),
    .frm_vld (frm_vld),
    .frm_ent (frm_ent)
  );

  // Overrun bookkeeping: remember a loss, tag the next stored entry
  assign push = frm_vld & (fill != C_MAX);

  always_comb begin
    push_ent     = frm_ent;
    push_ent.ovr = lost_q;
    lost_d       = lost_q;
    if (!rx_en)                        lost_d = 1'b0;
    else if (frm_vld && fill == C_MAX) lost_d = 1'b1;
    else if (push)                     lost_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lost_q <= 1'b0;
    else        lost_q <= lost_d;
  end

  uart_rxs_fifo #(.DEPTH(DEPTH), .W(ENT_W)) i_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (~rx_en),
    .push  (push),
    .din   (push_ent),
    .pop   (rd_pop),
    .dout  (head_ent),
    .fill  (fill)
  );

  assign data_rdy    = (fill != '0);
  assign fifo_half   = (fill >= C_HALF);
  assign fifo_full   = (fill >= C_FULL);
  assign rd_data     = head_ent.data;
  assign err_frame   = head_ent.fe;
  assign err_parity  = head_ent.pe;
  assign err_break   = head_ent.brk;
  assign err_overrun = head_ent.ovr;

  assign rts_n = rts_auto ? fifo_full : ~rts_sw;
  assign irq   = |(irq_en & {fifo_full, fifo_half, data_rdy});

endmodule

// File: rtl/uart_rxs_chk.sv
module uart_rxs_chk
  import uart_rxs_pkg::*;
#(
  parameter int DEPTH = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_en,
  input logic                       char8,
  input logic                       par_en,
  input logic                       rts_auto,
  input logic                       rts_n,
  input logic                       rd_pop,
  input logic                       data_rdy,
  input logic                       fifo_half,
  input logic                       fifo_full,
  input logic                       frm_vld,
  input rxs_ent_t                   frm_ent,
  input logic                       push,
  input logic [$clog2(DEPTH+1)-1:0] fill
);

  p_flush_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !data_rdy);

  p_seven_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && !char8) |-> !frm_ent.data[7]);

  p_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && data_rdy && !push && rx_en) |=> (fill == $past(fill) - 1'b1));

  p_full_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> fifo_half);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH+1))'(DEPTH));

  p_break_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && frm_ent.brk) |-> frm_ent.fe);

  p_parity_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && !par_en) |-> !frm_ent.pe);

  p_rts_auto_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_auto && fifo_full) |-> rts_n);

endmodule

bind uart_rxs_top uart_rxs_chk #(.DEPTH(DEPTH)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_en    (rx_en),
  .char8    (char8),
  .par_en   (par_en),
  .rts_auto (rts_auto),
  .rts_n    (rts_n),
  .rd_pop   (rd_pop),
  .data_rdy (data_rdy),
  .fifo_half(fifo_half),
  .fifo_full(fifo_full),
  .frm_vld  (frm_vld),
  .frm_ent  (frm_ent),
  .push     (push),
  .fill     (fill)
);

// File: tb/test_uart_rxs_top.sv
module test_uart_rxs_top;

  logic       clk;
  logic       rst_n;
  logic       baud_tick;
  logic       rxd, loop_txd, loop_en, rx_en;
  logic       char8, par_en, par_odd, rts_auto, rts_sw;
  logic [2:0] irq_en;
  logic       rd_pop;
  logic [7:0] rd_data;
  logic       data_rdy, fifo_half, fifo_full;
  logic       err_frame, err_parity, err_break, err_overrun;
  logic       rts_n, irq;

  int errors = 0;
  int checks = 0;

  uart_rxs_top i_uart_rxs_top (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .loop_txd(loop_txd), .loop_en(loop_en), .rx_en(rx_en), .char8(char8),
    .par_en(par_en), .par_odd(par_odd), .rts_auto(rts_auto), .rts_sw(rts_sw),
    .irq_en(irq_en), .rd_pop(rd_pop), .rd_data(rd_data), .data_rdy(data_rdy),
    .fifo_half(fifo_half), .fifo_full(fifo_full), .err_frame(err_frame),
    .err_parity(err_parity), .err_break(err_break), .err_overrun(err_overrun),
    .rts_n(rts_n), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic       c8;
    logic       pen;
    logic       odd;
    logic [7:0] d;
    logic       badp;
    logic       stop;
    logic [7:0] xd;
    logic       xfe;
    logic       xpe;
    logic       xbrk;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,8'hA5,1'b0,1'b1,8'hA5,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,8'hD3,1'b0,1'b1,8'h53,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,8'h37,1'b0,1'b1,8'h37,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b1,8'h37,1'b1,1'b1,8'h37,1'b0,1'b1,1'b0},
    '{1'b1,1'b1,1'b1,8'h37,1'b0,1'b1,8'h37,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,8'h00,1'b1,1'b0,1'b1},
    '{1'b1,1'b1,1'b1,8'h00,1'b1,1'b0,8'h00,1'b1,1'b1,1'b1},
    '{1'b1,1'b1,1'b0,8'h00,1'b0,1'b0,8'h00,1'b1,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,8'hFF,1'b0,1'b0,8'hFF,1'b1,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,8'h41,1'b0,1'b1,8'h41,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,8'h41,1'b1,1'b1,8'h41,1'b0,1'b1,1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic hold_bit(input logic v, input logic use_loop);
    if (use_loop) loop_txd = v; else rxd = v;
    repeat (16) @(negedge clk);
  endtask

  // Sends one frame with LSB first data, optional parity, one stop bit,
  // then one idle bit time so the character lands before checking.
  task automatic send(input logic c8, input logic pen, input logic odd,
                      input logic [7:0] d, input logic badp, input logic stp,
                      input logic use_loop);
    logic [7:0] ds;
    logic       p;
    ds = c8 ? d : {1'b0, d[6:0]};
    p  = (^ds) ^ odd ^ badp;
    hold_bit(1'b0, use_loop);
    for (int i = 0; i < (c8 ? 8 : 7); i++) hold_bit(d[i], use_loop);
    if (pen) hold_bit(p, use_loop);
    hold_bit(stp, use_loop);
    hold_bit(1'b1, use_loop);
  endtask

  task automatic pop1();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    baud_tick = 1'b1;
    rxd = 1'b1; loop_txd = 1'b1; loop_en = 1'b0; rx_en = 1'b0;
    char8 = 1'b1; par_en = 1'b0; par_odd = 1'b0;
    rts_auto = 1'b0; rts_sw = 1'b0; irq_en = 3'b000; rd_pop = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state (R1, R12, R10)
    chk("R1 reset data_rdy", data_rdy, 0);
    chk("R1 reset half", fifo_half, 0);
    chk("R1 reset full", fifo_full, 0);
    irq_en = 3'b111;
    @(negedge clk);
    chk("R12 reset irq", irq, 0);
    irq_en = 3'b000;
    chk("R10 manual rts_sw=0", rts_n, 1);
    rts_sw = 1'b1;
    @(negedge clk);
    chk("R10 manual rts_sw=1", rts_n, 0);
    rts_sw = 1'b0;

    // R1: disabled receiver ignores a frame
    send(1'b1, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0);
    chk("R1 disabled no receive", data_rdy, 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table: formats, parity, framing, break (R2 R5 R6 R7 R13)
    for (int v = 0; v < NV; v++) begin
      char8 = TBL[v].c8; par_en = TBL[v].pen; par_odd = TBL[v].odd;
      send(TBL[v].c8, TBL[v].pen, TBL[v].odd, TBL[v].d, TBL[v].badp, TBL[v].stop, 1'b0);
      chk("R3 data_rdy set", data_rdy, 1);
      chk("R2 R13 data", rd_data, TBL[v].xd);
      chk("R7 frame", err_frame, TBL[v].xfe);
      chk("R6 parity", err_parity, TBL[v].xpe);
      chk("R5 break", err_break, TBL[v].xbrk);
      chk("R8 no overrun", err_overrun, 0);
      pop1();
      chk("R3 data_rdy clear", data_rdy, 0);
    end
    char8 = 1'b1; par_en = 1'b0; par_odd = 1'b0;

    // R11: short glitch does not start a character
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    chk("R11 glitch rejected", data_rdy, 0);

    // R9: loopback takes loop_txd, ignores rxd
    loop_en = 1'b1;
    rxd = 1'b0;
    send(1'b1, 1'b0, 1'b0, 8'h6E, 1'b0, 1'b1, 1'b1);
    chk("R9 loopback data_rdy", data_rdy, 1);
    chk("R9 loopback data", rd_data, 8'h6E);
    pop1();
    rxd = 1'b1;
    send(1'b1, 1'b0, 1'b0, 8'h12, 1'b0, 1'b1, 1'b0);
    chk("R9 rxd ignored", data_rdy, 0);
    loop_en = 1'b0;

    // R4 R10 R12 R8: fill thresholds and overrun
    rts_auto = 1'b1;
    irq_en = 3'b001;
    for (int n = 1; n <= 13; n++) begin
      send(1'b1, 1'b0, 1'b0, 8'(n), 1'b0, 1'b1, 1'b0);
      if (n == 1) begin
        chk("R12 irq ready enabled", irq, 1);
        irq_en = 3'b110;
        @(negedge clk);
        chk("R12 irq masked", irq, 0);
      end
      if (n == 7)  chk("R4 half at 7", fifo_half, 0);
      if (n == 8) begin
        chk("R4 half at 8", fifo_half, 1);
        chk("R12 irq half", irq, 1);
      end
      if (n == 10) begin
        chk("R4 full at 10", fifo_full, 0);
        chk("R10 auto rts at 10", rts_n, 0);
      end
      if (n == 11) begin
        chk("R4 full at 11", fifo_full, 1);
        chk("R10 auto rts at 11", rts_n, 1);
      end
    end
    irq_en = 3'b000;
    for (int n = 1; n <= 12; n++) begin
      chk("R13 order", rd_data, 32'(n));
      chk("R8 kept entries clean", err_overrun, 0);
      pop1();
    end
    chk("R3 drained", data_rdy, 0);
    send(1'b1, 1'b0, 1'b0, 8'h99, 1'b0, 1'b1, 1'b0);
    chk("R8 overrun data", rd_data, 8'h99);
    chk("R8 overrun flag", err_overrun, 1);
    pop1();
    send(1'b1, 1'b0, 1'b0, 8'h55, 1'b0, 1'b1, 1'b0);
    chk("R8 overrun clears", err_overrun, 0);

    // R1: dropping enable flushes
    send(1'b1, 1'b0, 1'b0, 8'h77, 1'b0, 1'b1, 1'b0);
    chk("R1 two stored", data_rdy, 1);
    rx_en = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);
    chk("R1 flushed", data_rdy, 0);

    finish_run();
  end

endmodule